// File: doc/BRIEF.md
# Table-Driven Control Word Expander

This block turns a 71-bit compressed instruction into the 109-bit control word of a statically scheduled processor whose datapath is driven directly by wide control fields. The control word is split into eight signal groups. Each group has its own small table of bit patterns. A compressed instruction therefore carries one short index per group instead of the full pattern. The tables are built from flip-flops and can be rewritten at run time by instructions in the same stream.

The most significant input bit selects the instruction type. An expand instruction reads one entry from every table in parallel. The eight entries and a 32-bit immediate are presented, registered, on nine output buses. A table-load instruction carries two indices, two data fields and an eight-bit enable mask. With it, software can rewrite one entry in each of up to two tables in a single cycle. While loads are in progress, the outputs keep the last expanded word.

Top module: `ctlword_expander`

## Requirements
- R1: A synchronous active-high reset clears every output to zero and every table entry to zero. An expand instruction issued right after reset returns zero on all eight group buses.
- R2: When bit 70 is 0, the word is an expand instruction. Its indices sit at bits 69:64 (alu, 64 entries), 63:59 (rda, 32), 58:54 (rdb, 32), 53:48 (wb, 64), 47:44 (mem, 16), 43:40 (route, 16), 39:36 (seq, 16) and 35:32 (mul, 16). On the next rising edge each group output shows the entry at its index.
- R3: For an expand instruction, bits 31:0 appear on imm_out on the next rising edge.
- R4: When bit 70 is 1, the word is a load instruction. Mask bits 8:1 enable the tables, with bit 1+g enabling table g in the order alu, rda, rdb, wb, mem, route, seq, mul. The write takes effect on that edge, so an expand instruction in the very next cycle reads the new value.
- R5: In a load, the enabled table with the lowest mask bit takes the index at bits 69:64 and the data at bits 57:45. The next enabled table takes the index at bits 63:58 and the data at bits 44:32. Any further set mask bits write nothing.
- R6: A table narrower than the load fields uses only the low bits of the index and the low bits of the data.
- R7: During load instructions all nine outputs hold the value they had before.
- R8: A load whose mask is zero changes no table entry.
- R9: Entries and tables that a load does not address keep their contents.
- R10: Bits 31:9 and bit 0 of a load instruction have no effect on any table or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cw_in | input | 71 | Compressed instruction word |
| alu_ctl | output | 13 | Arithmetic unit control group |
| rda_ctl | output | 6 | Register read port A group |
| rdb_ctl | output | 6 | Register read port B group |
| wb_ctl | output | 10 | Register write-back group |
| mem_ctl | output | 13 | Load/store unit group |
| route_ctl | output | 10 | Interconnect and buffer group |
| seq_ctl | output | 9 | Program counter group |
| mul_ctl | output | 10 | Multiplier group |
| imm_out | output | 32 | Registered immediate |

## Verification
A wrong table entry stays hidden until an expand instruction selects that index. It then shows as a wrong group bus one edge later. For this reason, every load is followed at some point by reads of the written entry, of its unselected neighbours and of untouched tables. A wrong steering choice, such as a third mask bit that writes, or first and second slots that are swapped, shows up as a corrupted entry in a table that should have been left alone. A faulty hold path shows on the edge that follows each load, because the outputs must not move on that edge.

// File: rtl/cwx_pkg.sv
package cwx_pkg;

    localparam int NTAB       = 8;
    localparam int CW_W       = 71;
    localparam int IMM_W      = 32;
    localparam int TYPE_BIT   = CW_W - 1;
    localparam int LDIDX_W    = 6;
    localparam int LDDAT_W    = 13;
    localparam int LD_IDX0_LSB = TYPE_BIT - LDIDX_W;
    localparam int LD_IDX1_LSB = LD_IDX0_LSB - LDIDX_W;
    localparam int LD_DAT0_LSB = LD_IDX1_LSB - LDDAT_W;
    localparam int LD_DAT1_LSB = LD_DAT0_LSB - LDDAT_W;
    localparam int LD_CTL_LSB  = 1;

    // index width of table g (table 0 sits at the top of the word)
    function automatic int idx_w(input int g);
        case (g)
            0:       return 6;
            1:       return 5;
            2:       return 5;
            3:       return 6;
            default: return 4;
        endcase
    endfunction

    // entry width of table g
    function automatic int ent_w(input int g);
        case (g)
            0:       return 13;
            1:       return 6;
            2:       return 6;
            3:       return 10;
            4:       return 13;
            5:       return 10;
            6:       return 9;
            default: return 10;
        endcase
    endfunction

    function automatic int idx_lsb(input int g);
        int s;
        s = IMM_W;
        for (int k = g + 1; k < NTAB; k++) s += idx_w(k);
        return s;
    endfunction

    function automatic int ent_lsb(input int g);
        int s;
        s = 0;
        for (int k = g + 1; k < NTAB; k++) s += ent_w(k);
        return s;
    endfunction

    localparam int ENT_TOT = ent_lsb(-1);

endpackage

// File: rtl/load_steer.sv
module load_steer #(
    parameter int N_TAB = 8
) (
    input  logic [N_TAB-1:0] ctl,
    output logic [N_TAB-1:0] we,
    output logic [N_TAB-1:0] sec
);
    // lowest set bit takes slot 0, next takes slot 1, rest dropped
    always_comb begin
        logic [1:0] taken;
        taken = 2'd0;
        we    = '0;
        sec   = '0;
        for (int g = 0; g < N_TAB; g++) begin
            if (ctl[g] && (taken != 2'd2)) begin
                we[g]  = 1'b1;
                sec[g] = (taken == 2'd1);
                taken  = taken + 2'd1;
            end
        end
    end
endmodule

// File: rtl/lut_bank.sv
module lut_bank #(
    parameter int IDX_W = 4,
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    output logic [ENT_W-1:0] rd_q
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [ENT_W-1:0]            rd;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) bank_d.mem[wr_idx] = wr_data;
        if (rd_en) bank_d.rd = bank_q.mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign rd_q = bank_q.rd;

    // a write lands in the addressed entry on the same edge
    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bank_q.mem[$past(wr_idx)] == $past(wr_data));

    // read output moves only on a read
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/ctlword_expander.sv
module ctlword_expander
    import cwx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CW_W-1:0]     cw_in,
    output logic [ent_w(0)-1:0] alu_ctl,
    output logic [ent_w(1)-1:0] rda_ctl,
    output logic [ent_w(2)-1:0] rdb_ctl,
    output logic [ent_w(3)-1:0] wb_ctl,
    output logic [ent_w(4)-1:0] mem_ctl,
    output logic [ent_w(5)-1:0] route_ctl,
    output logic [ent_w(6)-1:0] seq_ctl,
    output logic [ent_w(7)-1:0] mul_ctl,
    output logic [IMM_W-1:0]    imm_out
);
    typedef struct packed {
        logic [IMM_W-1:0] imm;
    } top_t;

    top_t top_d, top_q;

    logic               is_load;
    logic [NTAB-1:0]    ld_ctl;
    logic [NTAB-1:0]    tab_we;
    logic [NTAB-1:0]    tab_sec;
    logic [ENT_TOT-1:0] ent_flat;

    assign is_load = cw_in[TYPE_BIT];
    assign ld_ctl  = is_load ? cw_in[LD_CTL_LSB +: NTAB] : '0;

    load_steer #(.N_TAB(NTAB)) u_steer (
        .ctl (ld_ctl),
        .we  (tab_we),
        .sec (tab_sec)
    );

    for (genvar g = 0; g < NTAB; g++) begin : g_tab
        localparam int IW = idx_w(g);
        localparam int EW = ent_w(g);
        localparam int IL = idx_lsb(g);
        localparam int EL = ent_lsb(g);

        logic [IW-1:0] w_idx;
        logic [EW-1:0] w_dat;

        assign w_idx = tab_sec[g] ? cw_in[LD_IDX1_LSB +: IW] : cw_in[LD_IDX0_LSB +: IW];
        assign w_dat = tab_sec[g] ? cw_in[LD_DAT1_LSB +: EW] : cw_in[LD_DAT0_LSB +: EW];

        lut_bank #(.IDX_W(IW), .ENT_W(EW)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .rd_en   (!is_load),
            .rd_idx  (cw_in[IL +: IW]),
            .wr_en   (tab_we[g]),
            .wr_idx  (w_idx),
            .wr_data (w_dat),
            .rd_q    (ent_flat[EL +: EW])
        );
    end

    always_comb begin
        top_d = top_q;
        if (!is_load) top_d.imm = cw_in[IMM_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign imm_out   = top_q.imm;
    assign alu_ctl   = ent_flat[ent_lsb(0) +: ent_w(0)];
    assign rda_ctl   = ent_flat[ent_lsb(1) +: ent_w(1)];
    assign rdb_ctl   = ent_flat[ent_lsb(2) +: ent_w(2)];
    assign wb_ctl    = ent_flat[ent_lsb(3) +: ent_w(3)];
    assign mem_ctl   = ent_flat[ent_lsb(4) +: ent_w(4)];
    assign route_ctl = ent_flat[ent_lsb(5) +: ent_w(5)];
    assign seq_ctl   = ent_flat[ent_lsb(6) +: ent_w(6)];
    assign mul_ctl   = ent_flat[ent_lsb(7) +: ent_w(7)];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (imm_out == '0 && ent_flat == '0));

    p_imm_follow_r3: assert property (@(posedge clk) disable iff (rst)
        !is_load |=> imm_out == $past(cw_in[IMM_W-1:0]));

    p_load_hold_r7: assert property (@(posedge clk) disable iff (rst)
        is_load |=> $stable({ent_flat, imm_out}));

    p_two_writes_max_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(tab_we) <= 2);

    p_we_in_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (tab_we & ~ld_ctl) == '0);

    p_no_write_on_expand_r2: assert property (@(posedge clk) disable iff (rst)
        !is_load |-> tab_we == '0);
endmodule

// File: tb/ctlword_expander_tb.sv
`timescale 1ns/1ps
module ctlword_expander_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [70:0] cw  = '0;
    logic [12:0] o_alu, o_mem;
    logic [5:0]  o_rda, o_rdb;
    logic [9:0]  o_wb, o_route, o_mul;
    logic [8:0]  o_seq;
    logic [31:0] o_imm;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [12:0]  mdl [8][64];
    logic [108:0] exp_q;

    always #2.5 clk = ~clk;

    ctlword_expander u_dut (
        .clk(clk), .rst(rst), .cw_in(cw),
        .alu_ctl(o_alu), .rda_ctl(o_rda), .rdb_ctl(o_rdb), .wb_ctl(o_wb),
        .mem_ctl(o_mem), .route_ctl(o_route), .seq_ctl(o_seq), .mul_ctl(o_mul),
        .imm_out(o_imm)
    );

    function automatic int iw(input int g);
        case (g) 0: return 6; 1: return 5; 2: return 5; 3: return 6; default: return 4; endcase
    endfunction

    function automatic int ew(input int g);
        case (g) 0: return 13; 1: return 6; 2: return 6; 3: return 10;
                 4: return 13; 5: return 10; 6: return 9; default: return 10; endcase
    endfunction

    function automatic logic [108:0] got_vec();
        return {o_alu, o_rda, o_rdb, o_wb, o_mem, o_route, o_seq, o_mul, o_imm};
    endfunction

    task automatic chk(input string tag, input logic [108:0] e);
        n_chk++;
        if (got_vec() !== e) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got_vec(), e);
        end
    endtask

    function automatic logic [70:0] mk_norm(input logic [7:0][5:0] ix, input logic [31:0] imm);
        logic [70:0] w;
        int p;
        w = '0;
        p = 70;
        for (int g = 0; g < 8; g++) begin
            p -= iw(g);
            for (int b = 0; b < iw(g); b++) w[p+b] = ix[g][b];
        end
        w[31:0] = imm;
        return w;
    endfunction

    function automatic logic [108:0] exp_norm(input logic [7:0][5:0] ix, input logic [31:0] imm);
        logic [108:0] r;
        logic [12:0]  e;
        int p;
        r = '0;
        r[31:0] = imm;
        p = 32;
        for (int g = 7; g >= 0; g--) begin
            e = mdl[g][int'(ix[g]) % (1 << iw(g))];
            for (int b = 0; b < ew(g); b++) r[p+b] = e[b];
            p += ew(g);
        end
        return r;
    endfunction

    function automatic logic [70:0] mk_load(input logic [5:0] i0, input logic [5:0] i1,
                                            input logic [12:0] d0, input logic [12:0] d1,
                                            input logic [7:0] ctl, input logic [22:0] junk,
                                            input logic b0);
        return {1'b1, i0, i1, d0, d1, junk, ctl, b0};
    endfunction

    function automatic void model_load(input logic [5:0] i0, input logic [5:0] i1,
                                       input logic [12:0] d0, input logic [12:0] d1,
                                       input logic [7:0] ctl);
        int taken;
        taken = 0;
        for (int g = 0; g < 8; g++) begin
            if (ctl[g] && taken < 2) begin
                mdl[g][int'(taken == 1 ? i1 : i0) % (1 << iw(g))] =
                    (taken == 1 ? d1 : d0) & 13'((1 << ew(g)) - 1);
                taken++;
            end
        end
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic step_norm(input logic [7:0][5:0] ix, input logic [31:0] imm, input string tag);
        logic [108:0] e;
        cw = mk_norm(ix, imm);
        e  = exp_norm(ix, imm);
        @(negedge clk);
        chk(tag, e);
        exp_q = e;
    endtask

    task automatic step_load(input logic [5:0] i0, input logic [5:0] i1,
                             input logic [12:0] d0, input logic [12:0] d1,
                             input logic [7:0] ctl, input logic [22:0] junk,
                             input logic b0, input string tag);
        cw = mk_load(i0, i1, d0, d1, ctl, junk, b0);
        model_load(i0, i1, d0, d1, ctl);
        @(negedge clk);
        chk(tag, exp_q);
    endtask

    function automatic logic [7:0][5:0] all_ix(input logic [5:0] v);
        logic [7:0][5:0] r;
        for (int g = 0; g < 8; g++) r[g] = v;
        return r;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0][5:0] ix;
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int g = 0; g < 8; g++)
            for (int i = 0; i < 64; i++) mdl[g][i] = '0;
        exp_q = '0;

        rst = 1'b1;
        cw  = mk_norm(all_ix(6'h3), 32'hDEAD_BEEF);
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", '0);
        rst = 1'b0;

        // R1: entries read zero after reset
        ix = {6'd9, 6'd1, 6'd2, 6'd30, 6'd31, 6'd17, 6'd63, 6'd5};
        step_norm(ix, 32'h1234_5678, "R1 entries zero");

        // R4: single table write, read back in the next cycle
        step_load(6'd5, 6'd0, 13'h1ABC, 13'h0, 8'b0000_0001, '0, 1'b0, "R7 hold on load");
        ix = all_ix(6'd5);
        step_norm(ix, 32'h0000_0001, "R4 alu write visible next cycle");

        // R5: two enables, slot order by lowest mask bit
        step_load(6'd7, 6'd11, 13'h0015, 13'h02A5, 8'b1000_0010, '0, 1'b0, "R7 hold on load");
        ix = '0; ix[1] = 6'd7; ix[7] = 6'd11;
        step_norm(ix, 32'hFFFF_FFFF, "R5 first slot rda second slot mul");

        // R5: third set bit writes nothing
        step_load(6'd3, 6'd4, 13'h0033, 13'h0155, 8'b0001_1100, '0, 1'b0, "R7 hold on load");
        ix = '0; ix[2] = 6'd3; ix[3] = 6'd4; ix[4] = 6'd3; ix[4] = 6'd4;
        step_norm(ix, 32'h0, "R5 third enable ignored");
        ix = all_ix(6'd3);
        step_norm(ix, 32'hA5A5_5A5A, "R5 mem untouched at first index");

        // R6: narrow table keeps low index and data bits
        step_load(6'h3A, 6'h00, 13'h1FFF, 13'h0, 8'b0100_0000, '0, 1'b0, "R7 hold on load");
        ix = all_ix(6'h0A);
        step_norm(ix, 32'h0BAD_F00D, "R6 seq low bits");

        // R8: empty mask writes nothing
        step_load(6'd5, 6'd5, 13'h0F0F, 13'h0F0F, 8'h00, 23'h7FFFFF, 1'b1, "R7 hold on load");
        ix = all_ix(6'd5);
        step_norm(ix, 32'h5555_AAAA, "R8 zero mask no write");

        // R10: junk in unused bits of a load
        step_load(6'd2, 6'd2, 13'h0ACE, 13'h0123, 8'b0000_1000, 23'h5A5A5A, 1'b1, "R10 junk bits");
        ix = all_ix(6'd2);
        step_norm(ix, 32'h0000_FFFF, "R10 junk bits no effect");

        // R9: untouched neighbours
        ix = all_ix(6'd6);
        step_norm(ix, 32'h8000_0000, "R9 neighbours intact");

        // R7: back-to-back loads hold the last expanded word
        step_load(6'd1, 6'd1, 13'h1111, 13'h0222, 8'b0011_0000, '0, 1'b0, "R7 hold first load");
        step_load(6'd2, 6'd2, 13'h0333, 13'h0044, 8'b1100_0000, '0, 1'b0, "R7 hold second load");
        ix = '0; ix[4] = 6'd1; ix[5] = 6'd1; ix[6] = 6'd2; ix[7] = 6'd2;
        step_norm(ix, 32'h0, "R4 two loads then read");

        // mixed random phase
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] < 3'd3) begin
                step_load(6'($urandom), 6'($urandom), 13'($urandom), 13'($urandom),
                          8'($urandom), 23'($urandom), 1'($urandom), "R7 random load hold");
            end else begin
                for (int g = 0; g < 8; g++) ix[g] = 6'($urandom);
                step_norm(ix, $urandom, "R2 random expand");
            end
        end

        // R3 immediate corners
        step_norm(all_ix(6'd0), 32'hFFFF_FFFF, "R3 immediate all ones");
        step_norm(all_ix(6'd0), 32'h0000_0000, "R3 immediate zero");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule